// File: doc/BRIEF.md
# Broadcast Audio Mode Routing Controller

This block chooses where the decoded audio of a multichannel television sound decoder goes. It takes two raw detector flags: stereo pilot present and second-language (SAP) carrier present. It also takes a small control word: output selection, forced mono, and one detection-sensitivity bit per detector. From these it produces a source select code for the left output and one for the right output, plus a two-bit mode indicator. The audio arithmetic lives elsewhere. This block produces only the select codes that steer it.

Each raw flag passes through its own qualifier state machine before it can affect the routing. The machine has four states. IDLE means the flag is clear. ARM counts consecutive high samples. LOCK means the flag is set. DROP counts consecutive low samples. The transitions are:

- IDLE to ARM on a high sample.
- ARM back to IDLE on any low sample.
- ARM to LOCK once the required run of high samples is complete.
- LOCK to DROP on a low sample.
- DROP back to LOCK on a high sample.
- DROP to IDLE once the release run of low samples is complete.

The qualified flag is set in LOCK and in DROP. A high sensitivity setting shortens the run needed to set the flag. Releasing always takes a fixed run, which gives the detector hysteresis against chatter.

The control inputs go into a shadow register only on a commit strobe. A half-written control word therefore never reaches the routing. The routing stage resolves a fixed priority and registers its results:

1. Mute.
2. Forced mono.
3. SAP-only selection.
4. Split selection.
5. Stereo.
6. Mono sum (the default).

Top module: `audio_route_ctrl`

## Requirements
- R1: While reset is applied, and right after reset is released, both select outputs carry the mono-sum code (3) and the mode code is 00. The committed selection resets to stereo (00), forced mono resets off, and both sensitivity bits reset low.
- R2: A committed selection of 11 (mute) drives both select outputs to the silence code (0), whatever the detector state and the forced-mono bit are.
- R3: When the committed forced-mono bit is 1 and the selection is not mute, both outputs carry the mono-sum code (3), whatever the detector state is.
- R4: When the qualified SAP flag is set and the selection is 01 (SAP), both outputs carry the SAP code (4).
- R5: When the qualified SAP flag is set and the selection is 10 (both), the left output carries mono sum (3) and the right output carries SAP (4).
- R6: When the qualified stereo flag is set and none of R2 to R5 applies, the left output carries L (1) and the right output carries R (2).
- R7: In every other case (no stereo flag, and SAP absent or not selected), both outputs carry mono sum (3).
- R8: The mode code is {stereo flag, SAP flag}: 00 mono, 01 SAP, 10 stereo, 11 stereo plus SAP. It does not depend on the selection, the mute setting or the forced-mono setting.
- R9: A qualified flag sets at the clock edge that samples its raw input high for the Nth consecutive time. N is FAST_CNT (default 4) when that detector's committed sensitivity bit is 1, and SLOW_CNT (default 8) when it is 0. Any low sample before the run is complete restarts the count.
- R10: A set flag clears at the edge that samples its raw input low for the REL_CNT-th consecutive time (default 3). A shorter run of low samples leaves the flag set.
- R11: Changes on the control inputs have no effect until cfg_commit is sampled high. The select outputs reflect a commit one clock edge after the edge that latched it.
- R12: The select outputs and the mode code change on the clock edge after the one on which a qualified flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_raw | input | 1 | Raw stereo pilot detector flag |
| sap_raw | input | 1 | Raw SAP carrier detector flag |
| cfg_sel | input | 2 | Output selection: 00 stereo, 01 SAP, 10 both, 11 mute |
| cfg_mono | input | 1 | Forced mono request |
| cfg_st_hi | input | 1 | Stereo detector high sensitivity |
| cfg_sap_hi | input | 1 | SAP detector high sensitivity |
| cfg_commit | input | 1 | Latches the control inputs into the shadow register |
| left_src | output | 3 | Left source: 0 silence, 1 L, 2 R, 3 L+R, 4 SAP |
| right_src | output | 3 | Right source, same encoding |
| mode_code | output | 2 | {stereo, SAP} detection indicator |

## Verification
A routing result is due two edges after the commit edge: the commit edge latches the control word, and the next edge registers the select codes. A change in detection is due one edge after the qualifier reaches its Nth consecutive sample, so the outputs change on edge N+1 of a raw run. The release takes effect on edge REL_CNT+1 of a low run. The directed timing tests drive inputs on the falling edge and sample one step before and at the due edge, which proves both that nothing moves early and that the result arrives on time. The table walk waits longer than the slowest qualification before checking each routing case.

// File: rtl/art_pkg.sv
package art_pkg;
    typedef enum logic [2:0] {
        SRC_MUTE = 3'd0,
        SRC_L    = 3'd1,
        SRC_R    = 3'd2,
        SRC_SUM  = 3'd3,
        SRC_SAP  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        SEL_STEREO = 2'b00,
        SEL_SAP    = 2'b01,
        SEL_BOTH   = 2'b10,
        SEL_MUTE   = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_ARM,
        Q_LOCK,
        Q_DROP
    } qstate_e;
endpackage

// File: rtl/det_qualifier.sv
// Debounce state machine for one detector flag. All counts must be at least 2.
module det_qualifier #(
    parameter int FAST_CNT = 4,
    parameter int SLOW_CNT = 8,
    parameter int REL_CNT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic sens_hi,
    output logic qual
);
    import art_pkg::*;

    localparam int MAX_A = (FAST_CNT > SLOW_CNT) ? FAST_CNT : SLOW_CNT;
    localparam int MAX_C = (MAX_A > REL_CNT) ? MAX_A : REL_CNT;
    localparam int CW    = $clog2(MAX_C + 1);

    qstate_e        state_q, state_n;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic [CW-1:0]  tgt;

    assign tgt = sens_hi ? CW'(FAST_CNT) : CW'(SLOW_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                if (raw) begin
                    state_n = Q_ARM;
                    cnt_n   = CW'(1);
                end
            end
            Q_ARM: begin
                if (!raw) begin
                    state_n = Q_IDLE;
                    cnt_n   = '0;
                end else if (cnt_q >= tgt - CW'(1)) begin
                    state_n = Q_LOCK;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            Q_LOCK: begin
                if (!raw) begin
                    state_n = Q_DROP;
                    cnt_n   = CW'(1);
                end
            end
            Q_DROP: begin
                if (raw) begin
                    state_n = Q_LOCK;
                    cnt_n   = '0;
                end else if (cnt_q >= CW'(REL_CNT - 1)) begin
                    state_n = Q_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: begin
                state_n = Q_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    assign qual = (state_q == Q_LOCK) || (state_q == Q_DROP);

    // R9
    qual_rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(raw));

    // R10
    qual_fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(qual) |-> !$past(raw));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  logic [1:0] sel_in,
    input  logic       mono_in,
    input  logic       st_hi_in,
    input  logic       sap_hi_in,
    output logic [1:0] sel_q,
    output logic       mono_q,
    output logic       st_hi_q,
    output logic       sap_hi_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 2'b00;
            mono_q   <= 1'b0;
            st_hi_q  <= 1'b0;
            sap_hi_q <= 1'b0;
        end else if (commit) begin
            sel_q    <= sel_in;
            mono_q   <= mono_in;
            st_hi_q  <= st_hi_in;
            sap_hi_q <= sap_hi_in;
        end
    end

    // R11
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({sel_q, mono_q, st_hi_q, sap_hi_q}));
endmodule

// File: rtl/route_matrix.sv
module route_matrix (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_det,
    input  logic       sap_det,
    input  logic [1:0] sel,
    input  logic       mono,
    output logic [2:0] left_o,
    output logic [2:0] right_o,
    output logic [1:0] mode_o
);
    import art_pkg::*;

    sel_e sel_v;
    src_e l_n, r_n, l_q, r_q;
    logic [1:0] mode_q;

    assign sel_v = sel_e'(sel);

    always_comb begin
        l_n = SRC_SUM;
        r_n = SRC_SUM;
        if (sel_v == SEL_MUTE) begin
            l_n = SRC_MUTE;
            r_n = SRC_MUTE;
        end else if (mono) begin
            l_n = SRC_SUM;
            r_n = SRC_SUM;
        end else if (sap_det && sel_v == SEL_SAP) begin
            l_n = SRC_SAP;
            r_n = SRC_SAP;
        end else if (sap_det && sel_v == SEL_BOTH) begin
            l_n = SRC_SUM;
            r_n = SRC_SAP;
        end else if (st_det) begin
            l_n = SRC_L;
            r_n = SRC_R;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q    <= SRC_SUM;
            r_q    <= SRC_SUM;
            mode_q <= 2'b00;
        end else begin
            l_q    <= l_n;
            r_q    <= r_n;
            mode_q <= {st_det, sap_det};
        end
    end

    assign left_o  = l_q;
    assign right_o = r_q;
    assign mode_o  = mode_q;

    // R2
    mute_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |=> (left_o == 3'd0 && right_o == 3'd0));

    // R3
    mono_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mono && sel != 2'b11) |=> (left_o == 3'd3 && right_o == 3'd3));

    // R8
    sap_route_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_o == 3'd4) |-> mode_o[0]);

    // R6
    stereo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_o == 3'd2) |-> (left_o == 3'd1 && mode_o[1]));
endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl #(
    parameter int FAST_CNT = 4,
    parameter int SLOW_CNT = 8,
    parameter int REL_CNT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_raw,
    input  logic       sap_raw,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_mono,
    input  logic       cfg_st_hi,
    input  logic       cfg_sap_hi,
    input  logic       cfg_commit,
    output logic [2:0] left_src,
    output logic [2:0] right_src,
    output logic [1:0] mode_code
);
    localparam int NDET = 2;

    logic [1:0] sel_q;
    logic       mono_q, st_hi_q, sap_hi_q;
    logic [NDET-1:0] raw_v, sens_v, qual_v;

    cfg_hold cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (cfg_commit),
        .sel_in    (cfg_sel),
        .mono_in   (cfg_mono),
        .st_hi_in  (cfg_st_hi),
        .sap_hi_in (cfg_sap_hi),
        .sel_q     (sel_q),
        .mono_q    (mono_q),
        .st_hi_q   (st_hi_q),
        .sap_hi_q  (sap_hi_q)
    );

    // index 1: stereo pilot, index 0: SAP carrier
    assign raw_v  = {st_raw, sap_raw};
    assign sens_v = {st_hi_q, sap_hi_q};

    for (genvar g = 0; g < NDET; g++) begin : g_det
        det_qualifier #(
            .FAST_CNT (FAST_CNT),
            .SLOW_CNT (SLOW_CNT),
            .REL_CNT  (REL_CNT)
        ) qual_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_v[g]),
            .sens_hi (sens_v[g]),
            .qual    (qual_v[g])
        );
    end

    route_matrix route_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_det  (qual_v[1]),
        .sap_det (qual_v[0]),
        .sel     (sel_q),
        .mono    (mono_q),
        .left_o  (left_src),
        .right_o (right_src),
        .mode_o  (mode_code)
    );
endmodule

// File: tb/audio_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module audio_route_ctrl_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, st_raw, sap_raw, cfg_mono, cfg_st_hi, cfg_sap_hi, cfg_commit;
    logic [1:0] cfg_sel;
    logic [2:0] left_src, right_src;
    logic [1:0] mode_code;

    audio_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .st_raw(st_raw), .sap_raw(sap_raw),
        .cfg_sel(cfg_sel), .cfg_mono(cfg_mono), .cfg_st_hi(cfg_st_hi),
        .cfg_sap_hi(cfg_sap_hi), .cfg_commit(cfg_commit),
        .left_src(left_src), .right_src(right_src), .mode_code(mode_code)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {st, sap, sel[1:0], mono, left[2:0], right[2:0], mode[1:0]}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0,1'b0,2'b00,1'b0,3'd3,3'd3,2'b00},  // R7
        {1'b1,1'b0,2'b00,1'b0,3'd1,3'd2,2'b10},  // R6
        {1'b1,1'b0,2'b01,1'b0,3'd1,3'd2,2'b10},  // R6
        {1'b1,1'b0,2'b10,1'b0,3'd1,3'd2,2'b10},  // R6
        {1'b0,1'b1,2'b01,1'b0,3'd4,3'd4,2'b01},  // R4
        {1'b0,1'b1,2'b10,1'b0,3'd3,3'd4,2'b01},  // R5
        {1'b0,1'b1,2'b00,1'b0,3'd3,3'd3,2'b01},  // R7
        {1'b1,1'b1,2'b00,1'b0,3'd1,3'd2,2'b11},  // R6
        {1'b1,1'b1,2'b01,1'b0,3'd4,3'd4,2'b11},  // R4
        {1'b1,1'b1,2'b10,1'b0,3'd3,3'd4,2'b11},  // R5
        {1'b1,1'b1,2'b11,1'b0,3'd0,3'd0,2'b11},  // R2
        {1'b1,1'b1,2'b01,1'b1,3'd3,3'd3,2'b11},  // R3
        {1'b0,1'b0,2'b11,1'b1,3'd0,3'd0,2'b00},  // R2
        {1'b1,1'b0,2'b00,1'b1,3'd3,3'd3,2'b10}   // R3
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [2:0] l, input logic [2:0] r,
                           input logic [1:0] m);
        chk({req, " left"},  {5'd0, left_src},  {5'd0, l});
        chk({req, " right"}, {5'd0, right_src}, {5'd0, r});
        chk({req, " mode"},  {6'd0, mode_code}, {6'd0, m});
    endtask

    task automatic commit(input logic [1:0] s, input logic m, input logic sh, input logic ah);
        cfg_sel = s; cfg_mono = m; cfg_st_hi = sh; cfg_sap_hi = ah;
        cfg_commit = 1'b1;
        step(1);
        cfg_commit = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; st_raw = 1'b0; sap_raw = 1'b0;
        cfg_sel = 2'b00; cfg_mono = 1'b0; cfg_st_hi = 1'b0; cfg_sap_hi = 1'b0;
        cfg_commit = 1'b0;
        step(3);
        chk_out("R1 in reset", 3'd3, 3'd3, 2'b00);
        rst_n = 1'b1;
        step(2);
        chk_out("R1 after reset", 3'd3, 3'd3, 2'b00);

        // routing matrix walk
        for (int i = 0; i < NV; i++) begin
            st_raw  = VEC[i][12];
            sap_raw = VEC[i][11];
            commit(VEC[i][10:9], VEC[i][8], 1'b1, 1'b1);
            step(12);
            chk_out($sformatf("R2-7 vector %0d", i), VEC[i][7:5], VEC[i][4:2], VEC[i][1:0]);
        end

        // clean state
        st_raw = 1'b0; sap_raw = 1'b0;
        commit(2'b00, 1'b0, 1'b1, 1'b1);
        step(12);
        chk_out("R7 clean", 3'd3, 3'd3, 2'b00);

        // R9 fast qualification and R12 latency
        st_raw = 1'b1;
        step(4);
        chk_out("R12 not yet", 3'd3, 3'd3, 2'b00);
        step(1);
        chk_out("R9 fast set", 3'd1, 3'd2, 2'b10);

        // R10 short dropout ignored
        st_raw = 1'b0;
        step(2);
        st_raw = 1'b1;
        step(3);
        chk_out("R10 dropout", 3'd1, 3'd2, 2'b10);
        st_raw = 1'b0;
        step(3);
        chk_out("R10 before release", 3'd1, 3'd2, 2'b10);
        step(1);
        chk_out("R10 released", 3'd3, 3'd3, 2'b00);

        // R9 slow qualification
        commit(2'b00, 1'b0, 1'b0, 1'b1);
        st_raw = 1'b1;
        step(8);
        chk_out("R9 slow not yet", 3'd3, 3'd3, 2'b00);
        step(1);
        chk_out("R9 slow set", 3'd1, 3'd2, 2'b10);
        st_raw = 1'b0;
        step(6);

        // R9 interrupted run restarts
        commit(2'b00, 1'b0, 1'b1, 1'b1);
        sap_raw = 1'b1;
        step(3);
        sap_raw = 1'b0;
        step(1);
        sap_raw = 1'b1;
        step(4);
        chk_out("R9 restart not yet", 3'd3, 3'd3, 2'b00);
        step(1);
        chk_out("R9 restart set", 3'd3, 3'd3, 2'b01);

        // R11 control ignored until commit
        cfg_sel = 2'b11; cfg_mono = 1'b1;
        step(4);
        chk_out("R11 uncommitted", 3'd3, 3'd3, 2'b01);
        cfg_commit = 1'b1;
        step(1);
        cfg_commit = 1'b0;
        chk_out("R11 commit edge", 3'd3, 3'd3, 2'b01);
        step(1);
        chk_out("R11 R8 muted", 3'd0, 3'd0, 2'b01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule